// File: doc/BRIEF.md
# Shared Memory Access Arbiter with Per-Port Protection

Two requesters share one 1 KB byte-wide memory: a contactless RF command engine and a two-wire serial bus engine. The block accepts one request at a time and owns the memory for the whole operation. The memory is organised as 8 blocks. Each block holds 8 pages, and each page is 16 bytes. A 16-byte protection page sits beside the memory and holds the access rights. Those rights are set separately for each port and each block. The protection page also holds write-protect bits for the pages of block 0 and a tamper flag. Every accepted request is checked against these rights before it touches any state.

Each port uses a valid/ready request with an address, a write enable and write data. A response comes back as a one-cycle pulse that carries an error flag and the read data. A refused request answers after a single cycle. A permitted request answers after a fixed number of cycles. During that time the other port is held off. When both ports ask in the same cycle, the port that was not served most recently goes first.

The tamper flag records any permitted RF access to the memory. Only the serial port can clear it, and it cannot set it. The serial bus master therefore learns when the contactless side has touched the memory.

Top module: `dual_port_mem_arbiter`

## Requirements
- R1: Address bit 10 = 0 selects memory byte addr[9:0], with block = addr[9:7] and page = addr[6:4]. Address bit 10 = 1 selects protection byte addr[3:0]. A permitted read returns the last value that a permitted write stored at that location.
- R2: A port's ready is high only while no operation is in progress and that port is the one chosen. Both readies never rise together. Both stay low from the accepting edge until the operation finishes. A requester holds valid and its fields steady until ready is high.
- R3: When both ports are valid in the same idle cycle, the port other than the one accepted most recently wins. After reset the RF port wins the first tie.
- R4: A permitted request raises that port's rsp_valid for exactly one cycle, OP_CYCLES clock edges after the accepting edge, with rsp_err = 0. A refused request does so 1 edge after acceptance, with rsp_err = 1.
- R5: Protection byte b (0..7) holds the rights for block b. The RF rights field is bits 5:4 and the serial rights field is bits 1:0. The codes are 00 = read and write, 01 = read only, 10 = write only, 11 = no access.
- R6: Bit p of protection byte 9 = 1 refuses writes from either port to page p of block 0, whatever the block's rights field says. Reads are not affected, and other blocks are not affected.
- R7: The serial port may always read and write the protection page. Every RF access to the protection page is refused.
- R8: Every permitted RF read or write of the memory sets the tamper flag. The flag appears on output tamper_flag and as bit 0 of protection byte 10.
- R9: A serial write to protection byte 10 stores bits 7:1 as written. It leaves bit 0 as (old bit 0 AND written bit 0), so it can clear the tamper flag but never set it.
- R10: A refused request changes no memory byte, no protection byte and not the tamper flag.
- R11: After reset all protection bytes are 0, the tamper flag is 0, and no response or ready is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_req_valid | input | 1 | RF request valid |
| rf_req_ready | output | 1 | RF request accepted this cycle |
| rf_req_addr | input | 11 | RF address (bit 10 selects protection page) |
| rf_req_we | input | 1 | RF write enable |
| rf_req_wdata | input | 8 | RF write data |
| rf_rsp_valid | output | 1 | RF response pulse |
| rf_rsp_err | output | 1 | RF response refused |
| rf_rsp_rdata | output | 8 | RF read data |
| sb_req_valid | input | 1 | Serial request valid |
| sb_req_ready | output | 1 | Serial request accepted this cycle |
| sb_req_addr | input | 11 | Serial address (bit 10 selects protection page) |
| sb_req_we | input | 1 | Serial write enable |
| sb_req_wdata | input | 8 | Serial write data |
| sb_rsp_valid | output | 1 | Serial response pulse |
| sb_rsp_err | output | 1 | Serial response refused |
| sb_rsp_rdata | output | 8 | Serial read data |
| tamper_flag | output | 1 | Tamper flag |

## Verification
The assertions assume that each requester keeps valid, address, write enable and data steady from the cycle it raises valid until it sees ready. They also assume that a requester never asks again while its own response is still pending. The bench meets both assumptions. It changes request signals only on falling edges, drops valid on the falling edge after an accept, and waits for each response before it issues the next request. The sweeps cover every rights code pair in every block and every write-protect bit against every page of block 0. A bench-side model decides which requests are permitted and what tamper and data values to expect.

// File: rtl/dpma_pkg.sv
package dpma_pkg;
   typedef enum logic [1:0] {
      RT_FULL   = 2'b00,
      RT_RDONLY = 2'b01,
      RT_WRONLY = 2'b10,
      RT_NONE   = 2'b11
   } rights_e;

   typedef enum logic {
      PORT_RF = 1'b0,
      PORT_SB = 1'b1
   } port_e;

   localparam int PROT_BYTES = 16;
   localparam int WP_IDX     = 9;
   localparam int TAMPER_IDX = 10;
endpackage

// File: rtl/dpma_rr_arbiter.sv
module dpma_rr_arbiter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idle,
   input  logic [1:0] req,
   output logic [1:0] gnt
);
   logic last_q;   // index of port accepted most recently

   always_comb begin
      gnt = 2'b00;
      if (idle) begin
         if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
         else              gnt = req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     last_q <= 1'b1;
      else if (|gnt)  last_q <= gnt[1];
   end

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_no_idle_starve_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && (|req)) |-> (|gnt));
endmodule

// File: rtl/dpma_rights_check.sv
module dpma_rights_check
   import dpma_pkg::*;
#(
   parameter int PG_W   = 3,
   parameter int RF_LSB = 4,
   parameter int SB_LSB = 0
) (
   input  logic            from_sb,
   input  logic            is_prot,
   input  logic            we,
   input  logic            blk_zero,
   input  logic [PG_W-1:0] page,
   input  logic [7:0]      blk_rights,
   input  logic [7:0]      wp_bits,
   output logic            allow
);
   if (RF_LSB == SB_LSB || RF_LSB > 6 || SB_LSB > 6) begin : g_bad_fields
      $error("rights fields overlap or leave the byte");
   end

   rights_e field;
   logic    wp_hit;

   assign field  = rights_e'(from_sb ? blk_rights[SB_LSB +: 2] : blk_rights[RF_LSB +: 2]);
   assign wp_hit = we && blk_zero && wp_bits[page];

   always_comb begin
      if (is_prot)      allow = from_sb;
      else if (wp_hit)  allow = 1'b0;
      else if (we)      allow = (field == RT_FULL) || (field == RT_WRONLY);
      else              allow = (field == RT_FULL) || (field == RT_RDONLY);
   end
endmodule

// File: rtl/dual_port_mem_arbiter.sv
module dual_port_mem_arbiter
   import dpma_pkg::*;
#(
   parameter int NUM_BLOCKS      = 8,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int PAGE_BYTES      = 16,
   parameter int OP_CYCLES       = 3,
   localparam int MEM_BYTES = NUM_BLOCKS * PAGES_PER_BLOCK * PAGE_BYTES,
   localparam int MEM_AW    = $clog2(MEM_BYTES),
   localparam int ADDR_W    = MEM_AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rf_req_valid,
   output logic              rf_req_ready,
   input  logic [ADDR_W-1:0] rf_req_addr,
   input  logic              rf_req_we,
   input  logic [7:0]        rf_req_wdata,
   output logic              rf_rsp_valid,
   output logic              rf_rsp_err,
   output logic [7:0]        rf_rsp_rdata,
   input  logic              sb_req_valid,
   output logic              sb_req_ready,
   input  logic [ADDR_W-1:0] sb_req_addr,
   input  logic              sb_req_we,
   input  logic [7:0]        sb_req_wdata,
   output logic              sb_rsp_valid,
   output logic              sb_rsp_err,
   output logic [7:0]        sb_rsp_rdata,
   output logic              tamper_flag
);
   localparam int BLK_W = $clog2(NUM_BLOCKS);
   localparam int PG_W  = $clog2(PAGES_PER_BLOCK);
   localparam int CNT_W = $clog2(OP_CYCLES);

   if (NUM_BLOCKS < 2 || NUM_BLOCKS > 8 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two from 2 to 8");
   end
   if (PAGES_PER_BLOCK < 2 || PAGES_PER_BLOCK > 8 || (1 << PG_W) != PAGES_PER_BLOCK) begin : g_bad_pages
      $error("PAGES_PER_BLOCK must be a power of two from 2 to 8");
   end
   if (PAGE_BYTES < 16 || (1 << $clog2(PAGE_BYTES)) != PAGE_BYTES) begin : g_bad_page_bytes
      $error("PAGE_BYTES must be a power of two of at least 16");
   end
   if (OP_CYCLES < 2) begin : g_bad_op
      $error("OP_CYCLES must be at least 2");
   end

   // ---------------- request selection ----------------
   logic [1:0]        req_v, gnt;
   logic              busy_q;
   logic [ADDR_W-1:0] a_addr;
   logic              a_we, a_allow;
   logic [7:0]        a_wdata;
   logic [BLK_W-1:0]  a_blk;
   logic [PG_W-1:0]   a_page;
   logic [3:0]        a_blk_idx;
   logic [7:0]        prot_q [PROT_BYTES];

   assign req_v = {sb_req_valid, rf_req_valid};

   dpma_rr_arbiter u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .idle  (!busy_q),
      .req   (req_v),
      .gnt   (gnt)
   );

   assign rf_req_ready = gnt[0];
   assign sb_req_ready = gnt[1];

   assign a_addr    = gnt[1] ? sb_req_addr  : rf_req_addr;
   assign a_we      = gnt[1] ? sb_req_we    : rf_req_we;
   assign a_wdata   = gnt[1] ? sb_req_wdata : rf_req_wdata;
   assign a_blk     = a_addr[MEM_AW-1 -: BLK_W];
   assign a_page    = a_addr[MEM_AW-BLK_W-1 -: PG_W];
   assign a_blk_idx = 4'(a_blk);

   dpma_rights_check #(.PG_W(PG_W), .RF_LSB(4), .SB_LSB(0)) u_rights (
      .from_sb    (gnt[1]),
      .is_prot    (a_addr[ADDR_W-1]),
      .we         (a_we),
      .blk_zero   (a_blk == '0),
      .page       (a_page),
      .blk_rights (prot_q[a_blk_idx]),
      .wp_bits    (prot_q[WP_IDX]),
      .allow      (a_allow)
   );

   // ---------------- operation sequencing ----------------
   port_e             owner_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_we, lat_err;
   logic [7:0]        lat_wdata;
   logic              fin, lat_prot, commit;
   logic [3:0]        lat_off;

   assign fin      = busy_q && (cnt_q == '0);
   assign lat_prot = lat_addr[ADDR_W-1];
   assign lat_off  = lat_addr[3:0];
   assign commit   = fin && !lat_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         owner_q   <= PORT_RF;
         cnt_q     <= '0;
         lat_addr  <= '0;
         lat_we    <= 1'b0;
         lat_err   <= 1'b0;
         lat_wdata <= '0;
      end else if (|gnt) begin
         busy_q    <= 1'b1;
         owner_q   <= port_e'(gnt[1]);
         cnt_q     <= a_allow ? CNT_W'(OP_CYCLES - 1) : '0;
         lat_addr  <= a_addr;
         lat_we    <= a_we;
         lat_err   <= !a_allow;
         lat_wdata <= a_wdata;
      end else if (busy_q) begin
         if (fin) busy_q <= 1'b0;
         else     cnt_q  <= cnt_q - 1'b1;
      end
   end

   // ---------------- storage ----------------
   logic [7:0] mem_q [MEM_BYTES];

   always_ff @(posedge clk) begin
      if (commit && lat_we && !lat_prot) mem_q[lat_addr[MEM_AW-1:0]] <= lat_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PROT_BYTES; i++) prot_q[i] <= '0;
      end else if (commit) begin
         if (lat_we && lat_prot) begin
            if (lat_off == 4'(TAMPER_IDX))
               prot_q[TAMPER_IDX] <= {lat_wdata[7:1], prot_q[TAMPER_IDX][0] & lat_wdata[0]};
            else
               prot_q[lat_off] <= lat_wdata;
         end
         if (owner_q == PORT_RF) prot_q[TAMPER_IDX][0] <= 1'b1;
      end
   end

   assign tamper_flag = prot_q[TAMPER_IDX][0];

   // ---------------- responses ----------------
   logic [1:0] rsp_v_q;
   logic       rsp_err_q;
   logic [7:0] rsp_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q    <= '0;
         rsp_err_q  <= 1'b0;
         rsp_data_q <= '0;
      end else begin
         rsp_v_q <= '0;
         if (fin) begin
            rsp_v_q[owner_q] <= 1'b1;
            rsp_err_q        <= lat_err;
            rsp_data_q       <= lat_prot ? prot_q[lat_off] : mem_q[lat_addr[MEM_AW-1:0]];
         end
      end
   end

   assign rf_rsp_valid = rsp_v_q[0];
   assign sb_rsp_valid = rsp_v_q[1];
   assign rf_rsp_err   = rsp_err_q;
   assign sb_rsp_err   = rsp_err_q;
   assign rf_rsp_rdata = rsp_data_q;
   assign sb_rsp_rdata = rsp_data_q;

   // ---------------- assertions ----------------
   assert_one_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_req_ready && sb_req_ready));
   assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (!rf_req_ready && !sb_req_ready));
   assert_refused_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && lat_err) |-> (cnt_q == '0));
   assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_rsp_valid |=> !rf_rsp_valid);
   assert_one_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_rsp_valid && sb_rsp_valid));
   assert_rf_prot_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && owner_q == PORT_RF && lat_prot) |-> lat_err);
   assert_tamper_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tamper_flag) |-> $past(fin && owner_q == PORT_RF && !lat_err));
   assert_tamper_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tamper_flag) |-> $past(fin && owner_q == PORT_SB && lat_we && lat_prot && !lat_err));
endmodule

// File: tb/sim_dual_port_mem_arbiter.sv
`timescale 1ns/1ps
module sim_dual_port_mem_arbiter;
   localparam int OP = 3;
   localparam int PB = 1024;  // protection page base address

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        rf_v = 0, rf_we = 0, sb_v = 0, sb_we = 0;
   logic [10:0] rf_a = '0, sb_a = '0;
   logic [7:0]  rf_d = '0, sb_d = '0;
   logic        rf_rdy, sb_rdy, rf_rv, sb_rv, rf_re, sb_re, tamper;
   logic [7:0]  rf_q, sb_q;

   dual_port_mem_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .rf_req_valid(rf_v), .rf_req_ready(rf_rdy), .rf_req_addr(rf_a), .rf_req_we(rf_we),
      .rf_req_wdata(rf_d), .rf_rsp_valid(rf_rv), .rf_rsp_err(rf_re), .rf_rsp_rdata(rf_q),
      .sb_req_valid(sb_v), .sb_req_ready(sb_rdy), .sb_req_addr(sb_a), .sb_req_we(sb_we),
      .sb_req_wdata(sb_d), .sb_rsp_valid(sb_rv), .sb_rsp_err(sb_re), .sb_rsp_rdata(sb_q),
      .tamper_flag(tamper));

   int checks = 0, failures = 0;
   bit done = 0;

   logic [7:0] m_mem [1024];
   bit         m_ok  [1024];
   logic [7:0] m_prot [16];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_allow(input bit sb, input int a, input bit we);
      int blk, pg;
      logic [1:0] f;
      bit ok;
      if (a >= PB) return sb;                                  // R7
      blk = (a >> 7) & 7;  pg = (a >> 4) & 7;                  // R1
      f = sb ? m_prot[blk][1:0] : m_prot[blk][5:4];            // R5
      ok = we ? (f == 2'b00 || f == 2'b10) : (f == 2'b00 || f == 2'b01);
      if (we && blk == 0 && m_prot[9][pg]) ok = 0;             // R6
      return ok;
   endfunction

   task automatic op(input bit sb, input int a, input bit we, input logic [7:0] wd,
                     output bit err, output logic [7:0] rd, output int lat);
      @(negedge clk);
      if (sb) begin sb_v = 1; sb_a = 11'(a); sb_we = we; sb_d = wd; end
      else    begin rf_v = 1; rf_a = 11'(a); rf_we = we; rf_d = wd; end
      #1;
      while (!(sb ? sb_rdy : rf_rdy)) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      if (sb) sb_v = 0; else rf_v = 0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!(sb ? sb_rv : rf_rv) && lat < 20);
      err = sb ? sb_re : rf_re;
      rd  = sb ? sb_q  : rf_q;
   endtask

   // run one access, check it against the model, update the model
   task automatic xop(input bit sb, input int a, input bit we, input logic [7:0] wd, input string req);
      bit err, al;
      logic [7:0] rd;
      int lat;
      al = exp_allow(sb, a, we);
      op(sb, a, we, wd, err, rd, lat);
      check(err == !al, req, err, !al);
      check(lat == (al ? OP : 1), "R4", lat, al ? OP : 1);
      if (al && !we) begin
         if (a >= PB)      check(rd == m_prot[a - PB], "R1", rd, m_prot[a - PB]);
         else if (m_ok[a]) check(rd == m_mem[a], "R1", rd, m_mem[a]);
      end
      if (al && we) begin
         if (a >= PB) begin
            if (a - PB == 10) m_prot[10] = {wd[7:1], m_prot[10][0] & wd[0]};  // R9
            else              m_prot[a - PB] = wd;
         end else begin
            m_mem[a] = wd; m_ok[a] = 1;
         end
      end
      if (al && !sb) m_prot[10][0] = 1'b1;                     // R8
      check(tamper == m_prot[10][0], "R8", tamper, m_prot[10][0]);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) m_ok[i] = 0;
      for (int i = 0; i < 16; i++) m_prot[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      // R11: reset state
      check(!rf_rv && !sb_rv, "R11", {rf_rv, sb_rv}, 0);
      check(!rf_rdy && !sb_rdy, "R11", {rf_rdy, sb_rdy}, 0);
      check(tamper == 0, "R11", tamper, 0);
      for (int i = 0; i < 16; i++) xop(1, PB + i, 0, 0, "R11");

      // R7 / R10: RF refused on protection page, nothing changes
      xop(0, PB + 0, 0, 0, "R7");
      xop(0, PB + 9, 1, 8'hFF, "R7");
      xop(1, PB + 9, 0, 0, "R10");
      // R9: serial cannot set tamper
      xop(1, PB + 10, 1, 8'h01, "R9");
      xop(1, PB + 10, 0, 0, "R9");
      // R8: RF access sets it
      xop(0, 5, 1, 8'hA5, "R8");
      xop(0, PB + 10, 1, 8'h00, "R10");
      xop(1, PB + 10, 1, 8'hFF, "R9");
      xop(1, PB + 10, 0, 0, "R9");
      xop(1, PB + 10, 1, 8'h02, "R9");
      xop(1, PB + 10, 0, 0, "R9");
      // R1: edge addresses
      xop(1, 1023, 1, 8'h3C, "R1");
      xop(0, 1023, 0, 0, "R1");
      xop(1, PB + 15, 1, 8'h77, "R1");
      xop(1, PB + 15, 0, 0, "R1");

      // R3 / R2: ties and blocking
      begin
         bit e; logic [7:0] r; int l;
         op(0, 16, 0, 0, e, r, l);   // RF served last
         m_prot[10][0] = 1'b1;
         @(negedge clk);
         rf_v = 1; rf_a = 11'd32; rf_we = 0;
         sb_v = 1; sb_a = 11'd48; sb_we = 0;
         #1;
         check(sb_rdy && !rf_rdy, "R3", {rf_rdy, sb_rdy}, 2'b01);
         @(posedge clk); @(negedge clk);
         sb_v = 0;
         for (int k = 0; k < OP; k++) begin
            check(!rf_rdy && !sb_rdy, "R2", {rf_rdy, sb_rdy}, 0);
            @(negedge clk);
         end
         check(sb_rv && rf_rdy, "R2", {sb_rv, rf_rdy}, 2'b11);
         @(posedge clk); @(negedge clk);
         rf_v = 0;
         for (int k = 0; k < OP; k++) @(negedge clk);
         check(rf_rv && !rf_re, "R4", {rf_rv, rf_re}, 2'b10);
         op(1, 16, 0, 0, e, r, l);   // serial served last
         @(negedge clk);
         rf_v = 1; sb_v = 1; #1;
         check(rf_rdy && !sb_rdy, "R3", {rf_rdy, sb_rdy}, 2'b10);
         @(posedge clk); @(negedge clk);
         rf_v = 0;
         for (int k = 0; k < OP; k++) @(negedge clk);
         @(posedge clk); @(negedge clk);
         sb_v = 0;
         for (int k = 0; k < OP; k++) @(negedge clk);
         check(sb_rv, "R2", sb_rv, 1);
      end

      // R5 sweep: every rights pair in every block, plus R10 via model
      for (int b = 0; b < 8; b++)
         for (int rf = 0; rf < 4; rf++)
            for (int sb = 0; sb < 4; sb++) begin
               int a;
               a = b * 128 + 16 * ((rf * 4 + sb) & 7) + b;
               xop(1, PB + b, 1, 8'((rf << 4) | sb), "R5");
               xop(0, a, 1, 8'(b * 16 + rf * 4 + sb), "R5");
               xop(0, a, 0, 0, "R5");
               xop(1, a, 1, 8'(~(b * 16 + rf * 4 + sb)), "R5");
               xop(1, a, 0, 0, "R5");
               xop(0, a, 0, 0, "R10");
            end
      for (int b = 0; b < 8; b++) xop(1, PB + b, 1, 0, "R5");

      // R6 sweep: write-protect bit p against every page of block 0
      for (int p = 0; p < 8; p++) begin
         xop(1, PB + 9, 1, 8'(1 << p), "R6");
         for (int q = 0; q < 8; q++) begin
            xop(0, q * 16 + 2, 1, 8'(p * 8 + q), "R6");
            xop(1, q * 16 + 3, 1, 8'(p * 8 + q + 64), "R6");
            xop(0, q * 16 + 2, 0, 0, "R6");
            xop(1, 128 + q * 16, 1, 8'(q), "R6");
         end
      end
      xop(1, PB + 9, 1, 0, "R6");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule